// File: doc/BRIEF.md
# External Interrupt Conditioning and Routing

This block takes twelve external interrupt request pins that may toggle at any moment, brings each one into the system clock domain, and gives each its own polarity and sense (level or edge). It merges the result with on-chip interrupt sources and with message-register interrupts. It then drives a single processor request line through a per-source enable mask, which stands in for a full priority arbiter. Each class of source has a fixed, known latency to the processor request.

A pass-through mode bypasses the mask. In that mode only external pin 0 reaches the processor request, and an active-low interrupt-out pin mirrors the raw OR of the on-chip sources. Two further asynchronous inputs are conditioned alongside:
- A machine-check pin. It is edge-captured and raises either a machine-check request or a sticky checkstop flag.
- A debug-event pin. It is level-followed.

Top module: `ext_irq_router`

## Requirements
- R1: While `rstN` is low, every output takes its idle value at the next clock edge: `coreReq`, `mcReq`, `checkStop` and `dbgReq` are 0, and `irqOutN` is 1.
- R2: An external pin in level sense (`extEdge[i]`=0) is active when it equals `extPol[i]` (1 means active-high, 0 means active-low). In normal mode, `coreReq` rises on the 4th rising edge after the pin becomes active and falls on the 4th rising edge after it becomes inactive.
- R3: An external pin in edge sense (`extEdge[i]`=1) latches a pending request on its inactive-to-active transition, with `coreReq` rising on the 4th edge. The request stays after the pin returns inactive. A one-cycle `extAck[i]` pulse clears it, and `coreReq` falls on the 2nd edge after the pulse is driven.
- R4: If a new active transition and `extAck` for the same edge-sense pin are seen at the same clock edge, the pending request is kept.
- R5: `srcEn` gates each source in normal mode. Bits [11:0] gate the external pins, the next `NUM_INT` bits gate the on-chip sources, and the top `NUM_MSG` bits gate the message registers. A source whose bit is 0 never raises `coreReq`. Setting the bit passes a pending source on the next edge.
- R6: An on-chip source `intSrc[j]` raises `coreReq` on the 2nd edge after it rises and drops it on the 2nd edge after it falls.
- R7: A `msgWr[k]` pulse sets message register k, and `coreReq` rises on the 2nd edge after the pulse. A `msgClr[k]` pulse clears it, with `coreReq` falling on the 2nd edge. When both pulses arrive in the same cycle, the write wins.
- R8: With `passMode`=1, `coreReq` follows only polarity-adjusted external pin 0, with 4-edge latency, and ignores `srcEn` and the other pins. In that mode `irqOutN` goes low on the 2nd edge after any `intSrc` bit rises and returns high 2 edges after all fall. With `passMode`=0, `irqOutN` stays high.
- R9: A machine-check pulse as short as one clock is captured. With `mcEnable`=1 it sets `mcReq` on the 3rd edge, and `mcReq` holds until an `mcAck` pulse clears it on the next edge. With `mcEnable`=0 it sets `checkStop` instead, which only reset clears.
- R10: `dbgReq` follows `udeIn` with a 3-edge delay in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| extIrq | input | 12 | Asynchronous external interrupt pins |
| extPol | input | 12 | Per-pin polarity, 1 = active high |
| extEdge | input | 12 | Per-pin sense, 1 = edge, 0 = level |
| extAck | input | 12 | Per-pin clear pulse for edge-sense pending requests |
| srcEn | input | 12+NUM_INT+NUM_MSG | Per-source enable mask |
| intSrc | input | NUM_INT | On-chip interrupt sources, synchronous |
| msgWr | input | NUM_MSG | Message register write strobes |
| msgClr | input | NUM_MSG | Message register clear strobes |
| passMode | input | 1 | Pass-through mode select |
| mcpIn | input | 1 | Asynchronous machine-check pin, active high |
| mcEnable | input | 1 | Machine checks enabled |
| mcAck | input | 1 | Clears the machine-check request |
| udeIn | input | 1 | Asynchronous debug-event pin, active high |
| coreReq | output | 1 | Processor interrupt request |
| irqOutN | output | 1 | Active-low interrupt-out pin |
| mcReq | output | 1 | Machine-check request |
| checkStop | output | 1 | Sticky checkstop flag |
| dbgReq | output | 1 | Debug-event request |

## Verification
Two pairs of events can land on the same clock edge: an acknowledge meeting a fresh edge on the same pin, and a message write meeting a message clear on the same register. For the first pair, the bench re-arms an edge-sense pin that is already pending. It drives the acknowledge exactly two cycles after the new transition, so that the acknowledge and the detected edge reach the pending bit on the same edge. The request must survive. For the second pair, it pulses write and clear together and expects the request two edges later.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int EXT_W = 12;
  localparam int SYNC_N = 2;

  typedef struct packed {
    logic [EXT_W-1:0] edgeSet;
    logic [EXT_W-1:0] lvlAct;
    logic             ptAct;
    logic             mcEdge;
    logic             dbgLvl;
  } strobe_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  input  logic rstVal,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{rstVal}};
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int STAGES = SYNC_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EXT_W-1:0] extIrq,
  input  logic [EXT_W-1:0] extPol,
  input  logic             mcpIn,
  input  logic             udeIn,
  output strobe_t          strb
);
  logic [EXT_W-1:0] extSync;
  logic [EXT_W-1:0] extAct;
  logic [EXT_W-1:0] actPrev;
  logic             mcpSync;
  logic             mcpPrev;
  logic             udeSync;

  // One synchronizer per pin; each resets to that pin's inactive level.
  for (genvar i = 0; i < EXT_W; i++) begin : g_extSync
    ext_irq_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .dIn(extIrq[i]), .rstVal(~extPol[i]), .qOut(extSync[i])
    );
  end

  ext_irq_sync #(.STAGES(STAGES)) u_mcpSync (
    .clk(clk), .rstN(rstN), .dIn(mcpIn), .rstVal(1'b0), .qOut(mcpSync)
  );

  ext_irq_sync #(.STAGES(STAGES)) u_udeSync (
    .clk(clk), .rstN(rstN), .dIn(udeIn), .rstVal(1'b0), .qOut(udeSync)
  );

  assign extAct = extSync ~^ extPol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPrev <= '1;
      mcpPrev <= 1'b0;
    end else begin
      actPrev <= extAct;
      mcpPrev <= mcpSync;
    end
  end

  always_comb begin
    strb.edgeSet = extAct & ~actPrev;
    strb.lvlAct  = extAct;
    strb.ptAct   = extAct[0];
    strb.mcEdge  = mcpSync & ~mcpPrev;
    strb.dbgLvl  = udeSync;
  end
endmodule

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_MSG = 2,
  localparam int NUM_SRC = EXT_W + NUM_INT + NUM_MSG
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [EXT_W-1:0]   extEdge,
  input  logic [EXT_W-1:0]   extAck,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_INT-1:0] intSrc,
  input  logic [NUM_MSG-1:0] msgWr,
  input  logic [NUM_MSG-1:0] msgClr,
  input  logic               passMode,
  input  logic               mcEnable,
  input  logic               mcAck,
  output logic               coreReq,
  output logic               irqOutN,
  output logic               mcReq,
  output logic               checkStop,
  output logic               dbgReq
);
  logic [EXT_W-1:0]   edgePend;
  logic [EXT_W-1:0]   lvlReg;
  logic               ptReg;
  logic [NUM_INT-1:0] intReg;
  logic [NUM_MSG-1:0] msgReg;
  logic [EXT_W-1:0]   extPend;
  logic [NUM_SRC-1:0] allPend;
  logic               reqNorm;
  logic               intAny;

  // Stage after the synchronizers: pending state per source class.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePend <= '0;
      lvlReg   <= '0;
      ptReg    <= 1'b0;
      intReg   <= '0;
      msgReg   <= '0;
    end else begin
      edgePend <= (strb.edgeSet & extEdge) | (edgePend & ~extAck);
      lvlReg   <= strb.lvlAct;
      ptReg    <= strb.ptAct;
      intReg   <= intSrc;
      msgReg   <= msgWr | (msgReg & ~msgClr);
    end
  end

  for (genvar i = 0; i < EXT_W; i++) begin : g_sense
    assign extPend[i] = extEdge[i] ? edgePend[i] : lvlReg[i];
  end

  assign allPend = {msgReg, intReg, extPend};
  assign reqNorm = |(allPend & srcEn);
  assign intAny  = |intReg;

  // Output stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreReq   <= 1'b0;
      irqOutN   <= 1'b1;
      mcReq     <= 1'b0;
      checkStop <= 1'b0;
      dbgReq    <= 1'b0;
    end else begin
      coreReq   <= passMode ? ptReg : reqNorm;
      irqOutN   <= passMode ? ~intAny : 1'b1;
      mcReq     <= (strb.mcEdge & mcEnable) | (mcReq & ~mcAck);
      checkStop <= checkStop | (strb.mcEdge & ~mcEnable);
      dbgReq    <= strb.dbgLvl;
    end
  end
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import ext_irq_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_MSG = 2,
  localparam int NUM_SRC = EXT_W + NUM_INT + NUM_MSG
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [EXT_W-1:0]   extIrq,
  input  logic [EXT_W-1:0]   extPol,
  input  logic [EXT_W-1:0]   extEdge,
  input  logic [EXT_W-1:0]   extAck,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_INT-1:0] intSrc,
  input  logic [NUM_MSG-1:0] msgWr,
  input  logic [NUM_MSG-1:0] msgClr,
  input  logic               passMode,
  input  logic               mcpIn,
  input  logic               mcEnable,
  input  logic               mcAck,
  input  logic               udeIn,
  output logic               coreReq,
  output logic               irqOutN,
  output logic               mcReq,
  output logic               checkStop,
  output logic               dbgReq
);
  strobe_t strb;

  ext_irq_ctrl #(.STAGES(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .extIrq(extIrq), .extPol(extPol),
    .mcpIn(mcpIn), .udeIn(udeIn), .strb(strb)
  );

  ext_irq_dp #(.NUM_INT(NUM_INT), .NUM_MSG(NUM_MSG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .extEdge(extEdge), .extAck(extAck),
    .srcEn(srcEn), .intSrc(intSrc), .msgWr(msgWr), .msgClr(msgClr),
    .passMode(passMode), .mcEnable(mcEnable), .mcAck(mcAck),
    .coreReq(coreReq), .irqOutN(irqOutN), .mcReq(mcReq),
    .checkStop(checkStop), .dbgReq(dbgReq)
  );
endmodule

// File: rtl/ext_irq_router_chk.sv
module ext_irq_router_chk (
  input logic clk,
  input logic rstN,
  input logic passMode,
  input logic mcAck,
  input logic udeIn,
  input logic coreReq,
  input logic irqOutN,
  input logic mcReq,
  input logic checkStop,
  input logic dbgReq
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1: reset drives all outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!coreReq && irqOutN && !mcReq && !checkStop && !dbgReq));

  // R8: outside pass-through the interrupt-out pin stays high
  a_r8_out_high: assert property (@(posedge clk) disable iff (!rstN)
    !passMode |=> irqOutN);

  // R9: checkstop is sticky until reset
  a_r9_chkstop_sticky: assert property (@(posedge clk) disable iff (!rstN)
    checkStop |=> checkStop);

  // R9: machine-check request holds without acknowledge
  a_r9_mc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mcReq && !mcAck) |=> mcReq);

  // R10: debug request is the debug pin three edges late
  a_r10_dbg_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) |-> (dbgReq == $past(udeIn, 3)));
endmodule

bind ext_irq_router ext_irq_router_chk u_chk (
  .clk(clk), .rstN(rstN), .passMode(passMode), .mcAck(mcAck), .udeIn(udeIn),
  .coreReq(coreReq), .irqOutN(irqOutN), .mcReq(mcReq),
  .checkStop(checkStop), .dbgReq(dbgReq)
);

// File: tb/ext_irq_router_tb.sv
module ext_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NM = 2;
  localparam int NS = 12 + NI + NM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] extIrq = '0, extPol = '1, extEdge = '0, extAck = '0;
  logic [NS-1:0] srcEn = '1;
  logic [NI-1:0] intSrc = '0;
  logic [NM-1:0] msgWr = '0, msgClr = '0;
  logic passMode = 1'b0, mcpIn = 1'b0, mcEnable = 1'b1, mcAck = 1'b0, udeIn = 1'b0;
  logic coreReq, irqOutN, mcReq, checkStop, dbgReq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_router #(.NUM_INT(NI), .NUM_MSG(NM)) u_dut (
    .clk(clk), .rstN(rstN), .extIrq(extIrq), .extPol(extPol), .extEdge(extEdge),
    .extAck(extAck), .srcEn(srcEn), .intSrc(intSrc), .msgWr(msgWr), .msgClr(msgClr),
    .passMode(passMode), .mcpIn(mcpIn), .mcEnable(mcEnable), .mcAck(mcAck),
    .udeIn(udeIn), .coreReq(coreReq), .irqOutN(irqOutN), .mcReq(mcReq),
    .checkStop(checkStop), .dbgReq(dbgReq)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitClk(3);
    chk("R1 coreReq", coreReq, 1'b0);
    chk("R1 irqOutN", irqOutN, 1'b1);
    chk("R1 mcReq", mcReq, 1'b0);
    chk("R1 checkStop", checkStop, 1'b0);
    chk("R1 dbgReq", dbgReq, 1'b0);
    rstN = 1'b1;
    waitClk(4);
  endtask

  task automatic testLevel();
    extIrq[3] = 1'b1;
    waitClk(3); chk("R2 hi early", coreReq, 1'b0);
    waitClk(1); chk("R2 hi on 4th", coreReq, 1'b1);
    extIrq[3] = 1'b0;
    waitClk(3); chk("R2 lo early", coreReq, 1'b1);
    waitClk(1); chk("R2 lo on 4th", coreReq, 1'b0);
    extPol[5] = 1'b0; extIrq[5] = 1'b1;
    waitClk(6); chk("R2 active-low idle", coreReq, 1'b0);
    extIrq[5] = 1'b0;
    waitClk(3); chk("R2 active-low early", coreReq, 1'b0);
    waitClk(1); chk("R2 active-low on 4th", coreReq, 1'b1);
    extIrq[5] = 1'b1;
    waitClk(4); chk("R2 active-low release", coreReq, 1'b0);
  endtask

  task automatic testEdge();
    extEdge[7] = 1'b1; extIrq[7] = 1'b1;
    waitClk(3); chk("R3 edge early", coreReq, 1'b0);
    waitClk(1); chk("R3 edge on 4th", coreReq, 1'b1);
    extIrq[7] = 1'b0;
    waitClk(6); chk("R3 held after release", coreReq, 1'b1);
    extAck[7] = 1'b1; waitClk(1); extAck[7] = 1'b0;
    chk("R3 ack 1st edge", coreReq, 1'b1);
    waitClk(1); chk("R3 ack 2nd edge", coreReq, 1'b0);
  endtask

  task automatic testCollide();
    extEdge[8] = 1'b1; extIrq[8] = 1'b1;
    waitClk(4); chk("R4 first edge", coreReq, 1'b1);
    extIrq[8] = 1'b0;
    waitClk(4);
    extIrq[8] = 1'b1;
    waitClk(2);
    extAck[8] = 1'b1; waitClk(1); extAck[8] = 1'b0;
    waitClk(3); chk("R4 edge beats ack", coreReq, 1'b1);
    extAck[8] = 1'b1; waitClk(1); extAck[8] = 1'b0;
    waitClk(1); chk("R4 plain ack clears", coreReq, 1'b0);
    extIrq[8] = 1'b0; extEdge[8] = 1'b0;
    waitClk(4);
  endtask

  task automatic testMask();
    srcEn[2] = 1'b0; extIrq[2] = 1'b1;
    waitClk(6); chk("R5 masked ext", coreReq, 1'b0);
    srcEn[2] = 1'b1;
    waitClk(1); chk("R5 unmask next edge", coreReq, 1'b1);
    extIrq[2] = 1'b0;
    waitClk(5); chk("R5 ext idle", coreReq, 1'b0);
    srcEn[12] = 1'b0; intSrc[0] = 1'b1;
    waitClk(3); chk("R5 masked int", coreReq, 1'b0);
    intSrc[0] = 1'b0; srcEn[12] = 1'b1;
    waitClk(3);
  endtask

  task automatic testInternal();
    intSrc[1] = 1'b1;
    waitClk(1); chk("R6 int early", coreReq, 1'b0);
    waitClk(1); chk("R6 int on 2nd", coreReq, 1'b1);
    intSrc[1] = 1'b0;
    waitClk(1); chk("R6 int fall early", coreReq, 1'b1);
    waitClk(1); chk("R6 int fall on 2nd", coreReq, 1'b0);
  endtask

  task automatic testMsg();
    msgWr[0] = 1'b1; waitClk(1); msgWr[0] = 1'b0;
    chk("R7 write early", coreReq, 1'b0);
    waitClk(1); chk("R7 write on 2nd", coreReq, 1'b1);
    waitClk(3); chk("R7 held", coreReq, 1'b1);
    msgClr[0] = 1'b1; waitClk(1); msgClr[0] = 1'b0;
    chk("R7 clear early", coreReq, 1'b1);
    waitClk(1); chk("R7 clear on 2nd", coreReq, 1'b0);
    msgWr[1] = 1'b1; msgClr[1] = 1'b1; waitClk(1);
    msgWr[1] = 1'b0; msgClr[1] = 1'b0;
    waitClk(1); chk("R7 write beats clear", coreReq, 1'b1);
    msgClr[1] = 1'b1; waitClk(1); msgClr[1] = 1'b0;
    waitClk(1); chk("R7 msg1 cleared", coreReq, 1'b0);
  endtask

  task automatic testPass();
    intSrc[3] = 1'b1; srcEn[15] = 1'b0;
    waitClk(3); chk("R8 normal irqOutN high", irqOutN, 1'b1);
    intSrc[3] = 1'b0; srcEn[15] = 1'b1;
    passMode = 1'b1; srcEn[0] = 1'b0; extIrq[4] = 1'b1;
    waitClk(5);
    chk("R8 other pin ignored", coreReq, 1'b0);
    chk("R8 irqOutN idle", irqOutN, 1'b1);
    extIrq[0] = 1'b1;
    waitClk(3); chk("R8 pin0 early", coreReq, 1'b0);
    waitClk(1); chk("R8 pin0 on 4th mask ignored", coreReq, 1'b1);
    intSrc[2] = 1'b1;
    waitClk(1); chk("R8 irqOutN early", irqOutN, 1'b1);
    waitClk(1); chk("R8 irqOutN low on 2nd", irqOutN, 1'b0);
    intSrc[2] = 1'b0;
    waitClk(2); chk("R8 irqOutN release", irqOutN, 1'b1);
    extIrq[0] = 1'b0;
    waitClk(4); chk("R8 pin0 release", coreReq, 1'b0);
    passMode = 1'b0; extIrq[4] = 1'b0; srcEn[0] = 1'b1;
    waitClk(5); chk("R8 back to normal idle", coreReq, 1'b0);
  endtask

  task automatic testMcp();
    mcEnable = 1'b1;
    mcpIn = 1'b1; waitClk(1); mcpIn = 1'b0;
    waitClk(1); chk("R9 mc early", mcReq, 1'b0);
    waitClk(1); chk("R9 mc on 3rd", mcReq, 1'b1);
    waitClk(5); chk("R9 mc held", mcReq, 1'b1);
    mcAck = 1'b1; waitClk(1); mcAck = 1'b0;
    chk("R9 mc acked", mcReq, 1'b0);
    chk("R9 no checkstop", checkStop, 1'b0);
    mcEnable = 1'b0;
    mcpIn = 1'b1; waitClk(1); mcpIn = 1'b0;
    waitClk(4);
    chk("R9 checkstop set", checkStop, 1'b1);
    chk("R9 no mc when disabled", mcReq, 1'b0);
    waitClk(4); chk("R9 checkstop sticky", checkStop, 1'b1);
    mcEnable = 1'b1;
  endtask

  task automatic testDbg();
    udeIn = 1'b1;
    waitClk(2); chk("R10 dbg early", dbgReq, 1'b0);
    waitClk(1); chk("R10 dbg on 3rd", dbgReq, 1'b1);
    waitClk(5); chk("R10 dbg held", dbgReq, 1'b1);
    udeIn = 1'b0;
    waitClk(2); chk("R10 dbg fall early", dbgReq, 1'b1);
    waitClk(1); chk("R10 dbg fall on 3rd", dbgReq, 1'b0);
  endtask

  initial begin
    doReset();
    testLevel();
    testEdge();
    testCollide();
    testMask();
    testInternal();
    testMsg();
    testPass();
    testMcp();
    testDbg();
    doReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule